// File: doc/BRIEF.md
# Fieldbus Manchester Frame Transmitter

This block takes bytes from a 16-entry transmit queue and sends them as one Manchester-coded frame on a single serial line. The line is shared with a receiver and runs half-duplex. A frame opens only when bytes are waiting, the receive side is idle and transmission is not inhibited. The frame is one or more preamble bytes, a start delimiter made partly of non-data symbols, and the queued data bytes. It closes with an end delimiter, which the block appends by itself as soon as the queue runs dry.

The bit rate is set outside the block. A one-cycle `half_tick` strobe marks every half-bit boundary. The queue has its own write port. It reports its occupancy, a programmable level alarm, a full flag and a sticky overflow flag, so a producer can keep the frame fed without losing bytes.

Top module: `fbt_tx`

## Requirements
- R1: The queue holds up to 16 bytes. It sends them in the order written. `fifo_level` reports the current occupancy, from 0 to 16.
- R2: A frame starts on a `half_tick` only while the queue is non-empty, `rx_busy` is low and `tx_inhibit` is low. At all other times `tx_active` stays low.
- R3: Each frame begins with preamble bytes of value 0x55, sent LSB first. The count is `pre_count`, except that a value of 0 gives one preamble byte.
- R4: Every symbol lasts two half-bits, and each half-bit runs from one `half_tick` to the next. A data bit b is sent as the inverse of b in the first half and b in the second half. The non-data symbol P is high in both halves. The non-data symbol M is low in both halves.
- R5: With `polarity` high the whole line is inverted. When no frame is active the line rests at the `polarity` value.
- R6: After the preamble the start delimiter is sent as the symbols 1,P,M,1,0,M,P,0. Data bytes then follow, each sent LSB first.
- R7: When a byte ends and the queue is empty, the end delimiter 1,P,M,P,M,1,0,1 is sent. The line then returns to rest and `tx_active` falls on the half_tick after its last half.
- R8: If `tx_inhibit` is high at the end of a symbol during a frame, the frame stops there. It returns to rest on that half_tick, and bytes still queued stay queued.
- R9: `level_alarm` is high while `thresh` is 1 to 15 and the occupancy is at least `thresh`. A `thresh` of 0 disables it. `fifo_full` is high at occupancy 16.
- R10: A write while the queue is full and not being read is dropped. It sets `overflow`, which stays high until reset.
- R11: After reset the line rests, and `tx_active`, `fifo_full`, `level_alarm` and `overflow` are low with occupancy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| rx_busy | input | 1 | Receive side is busy; blocks frame start |
| tx_inhibit | input | 1 | Blocks start, cuts an active frame |
| polarity | input | 1 | Inverts the line |
| pre_count | input | 3 | Preamble byte count (0 means 1) |
| half_tick | input | 1 | Half-bit rate strobe |
| thresh | input | 4 | Level alarm threshold |
| line_out | output | 1 | Serial Manchester line |
| tx_active | output | 1 | Frame in progress |
| fifo_level | output | 5 | Queue occupancy |
| fifo_full | output | 1 | Queue full |
| level_alarm | output | 1 | Occupancy at or above threshold |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The properties assume that `half_tick` is a single-cycle strobe and that `polarity` changes only while no frame runs. They also assume that `rx_busy` and `tx_inhibit` are only sampled at half-bit boundaries. The bench keeps to these rules. It writes to the queue and changes the mode inputs only between strobes, and only while the line is at rest, except where it deliberately raises `tx_inhibit` in mid-frame. It spaces the strobes two cycles apart, so every half-bit has a stable cycle in which to sample. Each frame's expected waveform is built from the symbol rules and compared half-bit by half-bit.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    localparam int SYMS = 8;
    localparam logic [7:0] PREAMBLE_BYTE = 8'h55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SD,
        ST_DATA,
        ST_ED
    } fbt_state_e;

    // nd = non-data symbol; val = line level (non-data) or bit value (data)
    typedef struct packed {
        logic nd;
        logic val;
    } fbt_sym_t;

    typedef fbt_sym_t [SYMS-1:0] fbt_syms_t;

    localparam fbt_sym_t S_D0 = '{nd: 1'b0, val: 1'b0};
    localparam fbt_sym_t S_D1 = '{nd: 1'b0, val: 1'b1};
    localparam fbt_sym_t S_NP = '{nd: 1'b1, val: 1'b1};
    localparam fbt_sym_t S_NM = '{nd: 1'b1, val: 1'b0};

    function automatic fbt_syms_t data_syms(input logic [7:0] b);
        fbt_syms_t s;
        for (int i = 0; i < SYMS; i++) begin
            s[i] = '{nd: 1'b0, val: b[i]};
        end
        return s;
    endfunction

    // index 0 leaves first
    function automatic fbt_syms_t start_syms();
        fbt_syms_t s;
        s[0] = S_D1; s[1] = S_NP; s[2] = S_NM; s[3] = S_D1;
        s[4] = S_D0; s[5] = S_NM; s[6] = S_NP; s[7] = S_D0;
        return s;
    endfunction

    function automatic fbt_syms_t end_syms();
        fbt_syms_t s;
        s[0] = S_D1; s[1] = S_NP; s[2] = S_NM; s[3] = S_NP;
        s[4] = S_NM; s[5] = S_D1; s[6] = S_D0; s[7] = S_D1;
        return s;
    endfunction

    function automatic logic half_level(input fbt_sym_t s, input logic second);
        if (s.nd) return s.val;
        return second ? s.val : ~s.val;
    endfunction

endpackage

// File: rtl/fbt_fifo.sv
module fbt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    input  logic [AW-1:0] thresh,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level,
    output logic          alarm,
    output logic          overflow
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);
    assign do_rd = pop && !empty;
    assign do_wr = wr_en && (!full || do_rd);
    assign head  = mem[rp];
    assign alarm = (thresh != '0) && (level >= CW'(thresh));

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd)      level <= level + 1'b1;
            else if (do_rd && !do_wr) level <= level - 1'b1;
            if (wr_en && !do_wr) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/fbt_seq.sv
module fbt_seq
    import fbt_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_tick,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_head,
    input  logic             rx_busy,
    input  logic             inhibit,
    input  logic [PRE_W-1:0] pre_count,
    output logic             pop,
    output logic             level,
    output logic             active
);

    localparam int IW = $clog2(SYMS);

    fbt_state_e        state;
    fbt_syms_t         syms;
    logic [IW-1:0]     idx;
    logic              second;
    logic [PRE_W-1:0]  pre_left;
    logic              sym_end, byte_end;

    assign active   = (state != ST_IDLE);
    assign sym_end  = half_tick && active && second;
    assign byte_end = sym_end && (idx == IW'(SYMS - 1)) && !inhibit;
    assign pop      = byte_end && ((state == ST_SD) ||
                                   (state == ST_DATA && !fifo_empty));
    assign level    = active ? half_level(syms[idx], second) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            syms     <= '0;
            idx      <= '0;
            second   <= 1'b0;
            pre_left <= '0;
        end else if (half_tick) begin
            if (state == ST_IDLE) begin
                if (!fifo_empty && !rx_busy && !inhibit) begin
                    state    <= ST_PRE;
                    syms     <= data_syms(PREAMBLE_BYTE);
                    idx      <= '0;
                    second   <= 1'b0;
                    pre_left <= (pre_count == '0) ? '0 : pre_count - 1'b1;
                end
            end else if (!second) begin
                second <= 1'b1;
            end else if (inhibit) begin
                state  <= ST_IDLE;
                second <= 1'b0;
                idx    <= '0;
            end else begin
                second <= 1'b0;
                idx    <= idx + 1'b1;
                if (idx == IW'(SYMS - 1)) begin
                    unique case (state)
                        ST_PRE: begin
                            if (pre_left != '0) begin
                                pre_left <= pre_left - 1'b1;
                                syms     <= data_syms(PREAMBLE_BYTE);
                            end else begin
                                state <= ST_SD;
                                syms  <= start_syms();
                            end
                        end
                        ST_SD: begin
                            state <= ST_DATA;
                            syms  <= data_syms(fifo_head);
                        end
                        ST_DATA: begin
                            if (!fifo_empty) begin
                                syms <= data_syms(fifo_head);
                            end else begin
                                state <= ST_ED;
                                syms  <= end_syms();
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/fbt_line.sv
module fbt_line (
    input  logic level,
    input  logic polarity,
    output logic line_out
);

    assign line_out = level ^ polarity;

endmodule

// File: rtl/fbt_tx.sv
module fbt_tx #(
    parameter int DEPTH = 16,
    parameter int PRE_W = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rx_busy,
    input  logic             tx_inhibit,
    input  logic             polarity,
    input  logic [PRE_W-1:0] pre_count,
    input  logic             half_tick,
    input  logic [AW-1:0]    thresh,
    output logic             line_out,
    output logic             tx_active,
    output logic [CW-1:0]    fifo_level,
    output logic             fifo_full,
    output logic             level_alarm,
    output logic             overflow
);

    logic [7:0] head;
    logic       fifo_empty, fifo_pop, enc_level;

    fbt_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .pop(fifo_pop), .thresh(thresh), .head(head), .empty(fifo_empty),
        .full(fifo_full), .level(fifo_level), .alarm(level_alarm),
        .overflow(overflow)
    );

    fbt_seq #(.PRE_W(PRE_W)) u_seq (
        .clk(clk), .rst(rst), .half_tick(half_tick), .fifo_empty(fifo_empty),
        .fifo_head(head), .rx_busy(rx_busy), .inhibit(tx_inhibit),
        .pre_count(pre_count), .pop(fifo_pop), .level(enc_level),
        .active(tx_active)
    );

    fbt_line u_line (
        .level(enc_level), .polarity(polarity), .line_out(line_out)
    );

endmodule

// File: rtl/fbt_tx_chk.sv
module fbt_tx_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rx_busy,
    input logic          tx_inhibit,
    input logic          polarity,
    input logic          half_tick,
    input logic          line_out,
    input logic          tx_active,
    input logic [CW-1:0] fifo_level,
    input logic          fifo_full,
    input logic          overflow,
    input logic          fifo_pop
);

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> $past(!rx_busy && !tx_inhibit && half_tick)); // R2

    AST_ACTIVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> $stable(tx_active)); // R4

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> ($stable(line_out) || !$stable(polarity))); // R4

    AST_REST_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> (line_out == polarity)); // R5

    AST_POP_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> tx_active); // R6

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= CW'(DEPTH)); // R1

    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && wr_en && !fifo_pop) |=> $stable(fifo_level)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R10

endmodule

bind fbt_tx fbt_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rx_busy(rx_busy),
    .tx_inhibit(tx_inhibit), .polarity(polarity), .half_tick(half_tick),
    .line_out(line_out), .tx_active(tx_active), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .overflow(overflow), .fifo_pop(fifo_pop)
);

// File: tb/tb_fbt_tx.sv
`timescale 1ns/1ps
module tb_fbt_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rx_busy = 1'b0;
    logic       tx_inhibit = 1'b0;
    logic       polarity = 1'b0;
    logic [2:0] pre_count = '0;
    logic       half_tick = 1'b0;
    logic [3:0] thresh = '0;
    logic       line_out, tx_active, fifo_full, level_alarm, overflow;
    logic [4:0] fifo_level;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] data_q[$];
    logic       exp_q[$];

    always #2.5 clk = ~clk;

    fbt_tx dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rx_busy(rx_busy), .tx_inhibit(tx_inhibit), .polarity(polarity),
        .pre_count(pre_count), .half_tick(half_tick), .thresh(thresh),
        .line_out(line_out), .tx_active(tx_active), .fifo_level(fifo_level),
        .fifo_full(fifo_full), .level_alarm(level_alarm), .overflow(overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk) half_tick = 1'b1;
        @(negedge clk) half_tick = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    // R4 symbol halves: data b -> ~b,b ; P -> 1,1 ; M -> 0,0
    task automatic add_sym(input logic nd, input logic v);
        exp_q.push_back(nd ? v : ~v);
        exp_q.push_back(v);
    endtask

    task automatic add_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) add_sym(1'b0, b[i]);
    endtask

    // frame of data_q: preamble (R3), start (R6), data, end (R7)
    task automatic run_frame(input logic [2:0] pre, input logic pol, input string tag);
        int npre;
        int bad;
        exp_q.delete();
        npre = (pre == 0) ? 1 : int'(pre);
        for (int i = 0; i < npre; i++) add_byte(8'h55);
        add_sym(0,1); add_sym(1,1); add_sym(1,0); add_sym(0,1);
        add_sym(0,0); add_sym(1,0); add_sym(1,1); add_sym(0,0);
        foreach (data_q[k]) add_byte(data_q[k]);
        add_sym(0,1); add_sym(1,1); add_sym(1,0); add_sym(1,1);
        add_sym(1,0); add_sym(0,1); add_sym(0,0); add_sym(0,1);
        pre_count = pre;
        polarity  = pol;
        rx_busy   = 1'b0;
        do_tick();
        chk({tag, " R2 active at start"}, tx_active, 1);
        bad = 0;
        foreach (exp_q[h]) begin
            n_chk++;
            if (line_out !== (exp_q[h] ^ pol) || tx_active !== 1'b1) begin
                n_fail++;
                bad++;
                if (bad < 4)
                    $display("FAIL %s R4 half %0d: actual %0d expected %0d",
                             tag, h, line_out, exp_q[h] ^ pol);
            end
            do_tick();
        end
        chk({tag, " R7 active falls"}, tx_active, 0);
        chk({tag, " R5 rest level"}, line_out, pol);
        chk({tag, " R7 queue drained"}, fifo_level, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 active", tx_active, 0);
        chk("R11 line", line_out, 0);
        chk("R11 level", fifo_level, 0);
        chk("R11 full", fifo_full, 0);
        chk("R11 alarm", level_alarm, 0);
        chk("R11 overflow", overflow, 0);
    endtask

    task automatic t_start_gate();
        do_reset();
        push(8'h11);
        rx_busy = 1'b1;
        repeat (3) do_tick();
        chk("R2 blocked by rx_busy", tx_active, 0);
        rx_busy = 1'b0;
        tx_inhibit = 1'b1;
        repeat (3) do_tick();
        chk("R2 blocked by inhibit", tx_active, 0);
        chk("R2 byte kept", fifo_level, 1);
        tx_inhibit = 1'b0;
        data_q = '{8'h11};
        run_frame(3'd2, 1'b0, "R3 two preambles");
    endtask

    task automatic t_polarity();
        do_reset();
        push(8'hA5);
        push(8'h3C);
        data_q = '{8'hA5, 8'h3C};
        run_frame(3'd0, 1'b1, "R5 inverted, R3 count zero");
        polarity = 1'b0;
    endtask

    task automatic t_full();
        do_reset();
        thresh = 4'd10;
        data_q.delete();
        for (int i = 0; i < 9; i++) begin
            push(8'(i * 17 + 3));
            data_q.push_back(8'(i * 17 + 3));
        end
        chk("R9 below threshold", level_alarm, 0);
        push(8'h9A); data_q.push_back(8'h9A);
        chk("R9 at threshold", level_alarm, 1);
        for (int i = 10; i < 16; i++) begin
            push(8'(i * 29 + 1));
            data_q.push_back(8'(i * 29 + 1));
        end
        chk("R9 full flag", fifo_full, 1);
        chk("R10 no overflow yet", overflow, 0);
        push(8'hEE);
        chk("R10 overflow set", overflow, 1);
        chk("R10 level kept", fifo_level, 16);
        thresh = 4'd0;
        @(negedge clk);
        chk("R9 threshold zero disables", level_alarm, 0);
        run_frame(3'd1, 1'b0, "R1 sixteen bytes in order");
        chk("R10 overflow sticky", overflow, 1);
    endtask

    task automatic t_inhibit();
        do_reset();
        push(8'h77);
        pre_count = 3'd1;
        do_tick();
        chk("R8 frame started", tx_active, 1);
        do_tick();
        do_tick();
        tx_inhibit = 1'b1;
        do_tick();
        chk("R8 finishes current symbol", tx_active, 1);
        do_tick();
        chk("R8 cut after symbol", tx_active, 0);
        chk("R8 line at rest", line_out, 0);
        chk("R8 byte still queued", fifo_level, 1);
        tx_inhibit = 1'b0;
    endtask

    initial begin
        t_reset();
        t_start_gate();
        t_polarity();
        t_full();
        t_inhibit();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule